// File: doc/BRIEF.md
# Lookahead Channel Scheduler

This block places announced data bursts onto one of several output data channels of a link, deciding before the burst turns up. Each channel holds one time value, its horizon. The horizon is the last instant the channel is already promised to be busy. A request gives the future arrival time of a burst and its duration. The block compares that arrival time against every horizon at once. It then answers one cycle later with either a grant naming a channel or a reject.

The choice looks ahead. A channel qualifies only if its horizon is not after the burst's arrival. Among the channels that qualify, the block takes the one whose horizon is latest, so that the idle gap left in front of the burst is as short as possible. A channel that happens to be free right now is not preferred for that reason. The chosen channel's horizon then moves to the end of the burst. A reject means the burst cannot go straight onto the link, and the surrounding logic may send it to burst storage instead. The block keeps no record of the gaps that earlier choices left behind, so it never fills them later.

All times live on a free-running counter of fixed width. They are compared modulo the counter range, so the schedule keeps working when the counter wraps. Every time the block compares must lie within half the counter range of the other. While reset is held, every horizon loads the current time given on an input.

Top module: `lookahead_chan_sched`

## Requirements
- R1: While `rst_n` is low at a clock edge, every horizon loads `now_time`, and both `rsp_grant` and `rsp_reject` read 0 after that edge.
- R2: A channel is eligible only when its horizon is at or before `req_arrival`. A horizon equal to the arrival time counts as eligible. A horizon one tick later does not.
- R3: Among the eligible channels, the one granted is the one whose horizon is latest, that is, closest to `req_arrival`.
- R4: When several eligible channels share the latest horizon, the one with the lowest index is granted.
- R5: After a grant, the granted channel's horizon becomes `req_arrival + req_duration`, modulo 2^TIME_W. No other horizon changes.
- R6: When no channel is eligible, the block answers with `rsp_reject`, and all horizons stay unchanged.
- R7: A request sampled at a clock edge is answered right after the next edge, with exactly one of `rsp_grant` or `rsp_reject` high. In a cycle that follows no request, both read 0.
- R8: Times are compared modulo 2^TIME_W. Time `a` is at or before time `b` when `(b - a) mod 2^TIME_W` has its top bit clear, so ordering holds across counter wrap.
- R9: A burst that would fit into an idle gap before some channel's horizon is still rejected when every horizon is later than its arrival.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| now_time | input | TIME_W | Current time, loaded into every horizon during reset |
| req_valid | input | 1 | A burst request is present this cycle |
| req_arrival | input | TIME_W | Arrival time of the burst at the output |
| req_duration | input | DUR_W | Burst length in time units |
| rsp_grant | output | 1 | The previous cycle's request was placed on a channel |
| rsp_reject | output | 1 | The previous cycle's request found no eligible channel |
| rsp_channel | output | IDX_W | Channel granted (valid with `rsp_grant`), IDX_W = clog2(NUM_CH) |

## Verification
Some behaviours are checked by assertions on every cycle:
- a response comes exactly one cycle after each request, and grant and reject never appear together;
- a granted channel was eligible, and no eligible channel had a later horizon;
- horizons load the reset time, take the burst end on a grant, and hold still on a reject.

Other behaviours only the bench's scenarios can show:
- the lowest index wins when horizons tie;
- the arrival boundary is inclusive;
- a burst that would fit in a gap is refused;
- the schedule stays correct across many counter wraps.

These are checked against a model of the horizons that the bench works out by arithmetic.

// File: rtl/lsch_pkg.sv
package lsch_pkg;
   // Kind of answer held in the response register
   typedef enum logic [1:0] {
      RSP_IDLE   = 2'd0,
      RSP_GRANT  = 2'd1,
      RSP_REJECT = 2'd2
   } rsp_kind_e;
endpackage

// File: rtl/lsch_channel.sv
// One channel: horizon register plus wrap-aware eligibility against the request
module lsch_channel #(
   parameter int TIME_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TIME_W-1:0] init_time,
   input  logic [TIME_W-1:0] arrival,
   input  logic              wr_en,
   input  logic [TIME_W-1:0] wr_value,
   output logic [TIME_W-1:0] horizon,
   output logic [TIME_W-1:0] age,
   output logic              eligible
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         horizon <= init_time;
      else if (wr_en)
         horizon <= wr_value;
   end

   // distance from horizon forward to arrival, modulo the counter range
   always_comb begin
      age      = arrival - horizon;
      eligible = ~age[TIME_W-1];
   end

   // R1
   horizon_init_chk: assert property (@(posedge clk)
      !rst_n |=> horizon == $past(init_time));

   // R5
   horizon_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> horizon == $past(wr_value));
endmodule

// File: rtl/lsch_select.sv
// Picks the eligible channel with the smallest age (latest horizon), lowest index on ties
module lsch_select #(
   parameter int NUM_CH = 8,
   parameter int TIME_W = 16,
   localparam int IDX_W = $clog2(NUM_CH)
) (
   input  logic [NUM_CH-1:0]             eligible,
   input  logic [NUM_CH-1:0][TIME_W-1:0] age,
   output logic                          found,
   output logic [IDX_W-1:0]              idx
);
   logic [TIME_W-1:0] best_age;

   always_comb begin
      found    = 1'b0;
      idx      = '0;
      best_age = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (eligible[i] && (!found || age[i] < best_age)) begin
            found    = 1'b1;
            idx      = IDX_W'(i);
            best_age = age[i];
         end
      end
   end

   always_comb begin
      if (found) begin
         // R2
         pick_eligible_chk: assert (eligible[idx]);
         for (int j = 0; j < NUM_CH; j++) begin
            if (eligible[j]) begin
               // R3
               pick_latest_chk: assert (age[idx] <= age[j]);
            end
         end
      end else begin
         // R6
         none_eligible_chk: assert (eligible == '0);
      end
   end
endmodule

// File: rtl/lookahead_chan_sched.sv
module lookahead_chan_sched
   import lsch_pkg::*;
#(
   parameter int NUM_CH = 8,
   parameter int TIME_W = 16,
   parameter int DUR_W  = 12,
   localparam int IDX_W = $clog2(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TIME_W-1:0] now_time,
   input  logic              req_valid,
   input  logic [TIME_W-1:0] req_arrival,
   input  logic [DUR_W-1:0]  req_duration,
   output logic              rsp_grant,
   output logic              rsp_reject,
   output logic [IDX_W-1:0]  rsp_channel
);
   // elaboration-time parameter checks
   if (NUM_CH < 2) begin : g_bad_ch
      $error("lookahead_chan_sched: NUM_CH must be at least 2");
   end
   if (DUR_W >= TIME_W) begin : g_bad_dur
      $error("lookahead_chan_sched: DUR_W must be below TIME_W");
   end

   logic [NUM_CH-1:0][TIME_W-1:0] hz;
   logic [NUM_CH-1:0][TIME_W-1:0] age;
   logic [NUM_CH-1:0]             elig;
   logic [NUM_CH-1:0]             wr_en;
   logic [TIME_W-1:0]             end_time;
   logic                          sel_found;
   logic [IDX_W-1:0]              sel_idx;
   rsp_kind_e                     rsp_q;
   logic [IDX_W-1:0]              ch_q;

   assign end_time = req_arrival + {{(TIME_W-DUR_W){1'b0}}, req_duration};

   always_comb begin
      for (int c = 0; c < NUM_CH; c++)
         wr_en[c] = req_valid && sel_found && (sel_idx == IDX_W'(c));
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      lsch_channel #(.TIME_W(TIME_W)) u_ch (
         .clk       (clk),
         .rst_n     (rst_n),
         .init_time (now_time),
         .arrival   (req_arrival),
         .wr_en     (wr_en[c]),
         .wr_value  (end_time),
         .horizon   (hz[c]),
         .age       (age[c]),
         .eligible  (elig[c])
      );
   end

   lsch_select #(.NUM_CH(NUM_CH), .TIME_W(TIME_W)) u_sel (
      .eligible (elig),
      .age      (age),
      .found    (sel_found),
      .idx      (sel_idx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_q <= RSP_IDLE;
         ch_q  <= '0;
      end else begin
         if (!req_valid)
            rsp_q <= RSP_IDLE;
         else if (sel_found)
            rsp_q <= RSP_GRANT;
         else
            rsp_q <= RSP_REJECT;
         ch_q <= sel_idx;
      end
   end

   assign rsp_grant   = (rsp_q == RSP_GRANT);
   assign rsp_reject  = (rsp_q == RSP_REJECT);
   assign rsp_channel = ch_q;

   // R7
   single_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rsp_grant && rsp_reject));

   // R7
   rsp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (rsp_grant || rsp_reject));

   // R7
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!rsp_grant && !rsp_reject));

   // R6
   reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !sel_found) |=> $stable(hz));

   // R5
   single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_en));
endmodule

// File: tb/lookahead_chan_sched_test.sv
module lookahead_chan_sched_test;
   localparam int NC = 4;
   localparam int TW = 8;
   localparam int DW = 6;
   localparam int IW = $clog2(NC);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [TW-1:0] now_time = '0;
   logic          req_valid = 1'b0;
   logic [TW-1:0] req_arrival = '0;
   logic [DW-1:0] req_duration = '0;
   logic          rsp_grant;
   logic          rsp_reject;
   logic [IW-1:0] rsp_channel;

   int checks = 0;
   int fails  = 0;
   int hz [NC];
   bit done = 0;

   always #2 clk = ~clk;   // 250 MHz

   lookahead_chan_sched #(.NUM_CH(NC), .TIME_W(TW), .DUR_W(DW)) uut (
      .clk, .rst_n, .now_time, .req_valid, .req_arrival, .req_duration,
      .rsp_grant, .rsp_reject, .rsp_channel
   );

   task automatic note(input bit ok, input string tag, input string what,
                       input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic do_reset(input int t);
      rst_n = 1'b0;
      now_time = t[TW-1:0];
      repeat (3) @(negedge clk);
      note(rsp_grant == 1'b0 && rsp_reject == 1'b0, "R1", "outputs in reset",
           {rsp_grant, rsp_reject}, 0);
      rst_n = 1'b1;
      for (int i = 0; i < NC; i++) hz[i] = t;
   endtask

   // model: wrap-aware age, eligible if top bit clear, smallest age wins, lowest index on tie
   task automatic issue(input int arr, input int dur, input string tag);
      int best = -1;
      int best_age = 0;
      for (int i = 0; i < NC; i++) begin
         int a = (arr - hz[i]) & ((1 << TW) - 1);
         if (a < (1 << (TW - 1)) && (best < 0 || a < best_age)) begin
            best = i;
            best_age = a;
         end
      end
      @(negedge clk);
      req_valid    = 1'b1;
      req_arrival  = arr[TW-1:0];
      req_duration = dur[DW-1:0];
      @(negedge clk);
      req_valid = 1'b0;
      if (best >= 0) begin
         note(rsp_grant == 1'b1 && rsp_reject == 1'b0, tag, "grant expected",
              {rsp_grant, rsp_reject}, 2);
         note(int'(rsp_channel) == best, tag, "granted channel", int'(rsp_channel), best);
         hz[best] = (arr + dur) & ((1 << TW) - 1);
      end else begin
         note(rsp_grant == 1'b0 && rsp_reject == 1'b1, tag, "reject expected",
              {rsp_grant, rsp_reject}, 1);
      end
      @(negedge clk);
      note(rsp_grant == 1'b0 && rsp_reject == 1'b0, "R7", "quiet after answer",
           {rsp_grant, rsp_reject}, 0);
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      int cursor;
      do_reset(200);
      issue(200, 10, "R1 R4");      // all horizons at reset time, tie -> ch0
      issue(205, 5,  "R2");         // ch0 busy to 210 -> ch1
      issue(210, 20, "R4");         // ch0 and ch1 both end at 210 -> ch0
      issue(209, 1,  "R2");         // ch1 ends at 210, one tick late -> ch2
      issue(210, 20, "R3");         // latest horizon wins -> ch1
      issue(210, 20, "R3");         // -> ch2
      issue(200, 30, "R3");         // -> ch3, all now end at 230
      issue(215, 2,  "R9");         // fits in old gaps, still refused
      issue(229, 63, "R6");         // one tick early everywhere -> reject
      issue(230, 5,  "R5 R6");      // end equals arrival, horizons untouched -> ch0

      do_reset(250);
      issue(3,   4, "R8");          // arrival past the wrap -> ch0, ends at 7
      issue(245, 2, "R8");          // before every horizon across wrap -> reject
      issue(7,   1, "R8");          // ch0 at 7 is latest -> ch0

      cursor = 8;
      for (int n = 0; n < 3000; n++) begin
         int arr = (cursor + int'($urandom_range(0, 31))) & 255;
         int dur = int'($urandom_range(1, 40));
         issue(arr, dur, "R3 R6 R8");
         cursor = (cursor + int'($urandom_range(0, 3))) & 255;
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule